// File: doc/BRIEF.md
# Half-Bridge Startup and Protection Sequencer

This block is the digital supervisor in front of a self-oscillating half-bridge pulse generator. It watches four digital levels: a supply-good flag, the brown-out comparator, the stop (enable) comparator and an over-temperature flag. From these it decides when the pulse generator may run.

Its outputs are:
- a driver enable;
- a control for the bias current sink on the brown-out sense pin;
- a switch control that grounds the timing pin, which holds the soft-start capacitor discharged;
- a one-cycle restart strobe, so the pulse generator always begins with its lower-side phase.

Both comparator inputs pass through persistence filters before the block uses them. A version select input picks one of two timer sets. The long set also honours the stop comparator. The short set keeps the same ratio between timers and ignores the stop comparator.

A power-up starts two timers together:
- a settling delay, during which the oscillator is held and the timing pin is grounded;
- a shorter forced-sink window, after which the filtered brown-out result takes over.

A later return of a healthy bulk level starts a fresh settling delay. Releasing the stop comparator or the over-temperature flag does not start one: pulsing resumes at once.

Top module: `hb_start_seq`

## Requirements
- R1: After the first clock edge that samples `supply_ok` high (edge E0), `drv_en` is 0 through edge E0+D-1 and rises after edge E0+D. D is `DLY_LONG_CYC` when `ver_short`=0 and `DLY_SHORT_CYC` when `ver_short`=1. This holds when `bulk_ok_raw` was high early enough to pass its filter before the window ends.
- R2: `ss_ground` is 1 whenever the supply is not good and for every cycle of a settling delay. It is 0 once the delay ends, and `drv_en` is never 1 while `ss_ground` is 1.
- R3: After power-up, `bias_sink_on` stays 1 through edge E0+W regardless of `bulk_ok_raw`. W is `WIN_LONG_CYC` or `WIN_SHORT_CYC`, chosen by `ver_short`. From edge E0+W+1 it is the inverse of the filtered brown-out result.
- R4: The brown-out level (`bulk_ok_raw`, 1 = bulk above threshold) is used only after it holds a new value for `BO_FILT_CYC` consecutive edges. A change lasting one edge less has no effect on any output. A held drop makes the filtered result change at edge `BO_FILT_CYC`. `bias_sink_on` rises and `drv_en` falls one edge later.
- R5: When the filtered brown-out result returns high after the window, `bias_sink_on` falls. A fresh settling delay starts on that same edge, and `drv_en` rises D edges later.
- R6: With `ver_short`=0, `stop_req_raw` (1 = stop) is filtered over `EN_FILT_CYC` edges. When the filtered level is 1, `drv_en` is 0 from the edge where it changes. On release, `drv_en` returns on the edge where the filter clears, with no settling delay and `ss_ground` staying 0.
- R7: With `ver_short`=1, `stop_req_raw` has no effect on `drv_en`.
- R8: `over_temp`=1 makes `drv_en` 0 after the next edge. When it returns to 0, `drv_en` is 1 again after the next edge, with no settling delay.
- R9: `restart_pulse` is 1 exactly in the first cycle of each period in which `drv_en` is 1, and 0 otherwise.
- R10: `supply_ok`=0 clears all state at the next edge: `drv_en`=0, `bias_sink_on`=1, `ss_ground`=1. The next rise of `supply_ok` repeats the full power-up sequence.
- R11: Reset gives `drv_en`=0, `restart_pulse`=0, `bias_sink_on`=1 and `ss_ground`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ver_short | input | 1 | 1 selects short timers with stop input ignored; change only while supply is down |
| supply_ok | input | 1 | Supply above turn-on level |
| bulk_ok_raw | input | 1 | Unfiltered brown-out comparator, 1 = bulk adequate |
| stop_req_raw | input | 1 | Unfiltered stop comparator, 1 = halt drivers |
| over_temp | input | 1 | Over-temperature flag |
| drv_en | output | 1 | Pulse generator may switch |
| bias_sink_on | output | 1 | Brown-out pin bias sink active |
| ss_ground | output | 1 | Ground the timing pin (soft-start discharge) |
| restart_pulse | output | 1 | One cycle at each start of switching |

## Verification
A timer counting one cycle wrong shows up at the ports as a shifted edge on `drv_en` or `bias_sink_on`. The bench samples those edges exactly at the predicted cycle and one cycle before it. A stuck or mis-captured healthy-bulk state shows as a settling delay that is missing or doubled after a brown-out recovery. It also shows as a delay wrongly inserted after a stop release, which `ss_ground` exposes in the first cycle. Filter length errors appear within `BO_FILT_CYC`+1 cycles, through sub-threshold glitches that must leave the outputs untouched and held changes that must move them on a known edge.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_DELAY,
        PH_WAIT,
        PH_HOLD,
        PH_RUN
    } phase_e;

    typedef struct packed {
        logic pwr;
        logic bulk_good;
        logic hot;
        logic drv_prev;
    } seq_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/ssq_deglitch.sv
module ssq_deglitch #(
    parameter int unsigned HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic din,
    output logic dout
);
    import ssq_pkg::*;

    localparam int unsigned CW = bits_for(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_cnt <= '0;
            dout    <= 1'b0;
        end else if (din == dout) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            run_cnt <= '0;
            dout    <= din;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R4: the filtered level only moves to a value the raw input held
    assert_follow_input_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> (dout == $past(din) || $past(clr)))
        else $error("filter output changed without matching input");

endmodule

// File: rtl/ssq_timer.sv
module ssq_timer #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         busy
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || clr)
            remain <= '0;
        else if (load)
            remain <= len;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    assert_load_starts_R1: assert property (@(posedge clk) disable iff (rst)
        (load && !clr && len != '0) |=> busy)
        else $error("timer did not start on load");

    assert_idle_stays_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> !busy)
        else $error("idle timer became busy without load");

endmodule

// File: rtl/hb_start_seq.sv
module hb_start_seq #(
    parameter int unsigned DLY_LONG_CYC  = 800,
    parameter int unsigned DLY_SHORT_CYC = 100,
    parameter int unsigned WIN_LONG_CYC  = 400,
    parameter int unsigned WIN_SHORT_CYC = 50,
    parameter int unsigned BO_FILT_CYC   = 8,
    parameter int unsigned EN_FILT_CYC   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ver_short,
    input  logic supply_ok,
    input  logic bulk_ok_raw,
    input  logic stop_req_raw,
    input  logic over_temp,
    output logic drv_en,
    output logic bias_sink_on,
    output logic ss_ground,
    output logic restart_pulse
);
    import ssq_pkg::*;

    localparam int unsigned TMAX = max2(max2(DLY_LONG_CYC, DLY_SHORT_CYC),
                                        max2(WIN_LONG_CYC, WIN_SHORT_CYC));
    localparam int unsigned CW   = bits_for(TMAX);
    localparam logic [CW-1:0] DLY_L = CW'(DLY_LONG_CYC);
    localparam logic [CW-1:0] DLY_S = CW'(DLY_SHORT_CYC);
    localparam logic [CW-1:0] WIN_L = CW'(WIN_LONG_CYC);
    localparam logic [CW-1:0] WIN_S = CW'(WIN_SHORT_CYC);

    seq_state_t st;
    phase_e     phase;

    logic bulk_filt, stop_filt;
    logic win_busy, dly_busy;
    logic sup_rise, bulk_next, bulk_restart, stop_active;
    logic [CW-1:0] win_len, dly_len;

    assign sup_rise = supply_ok && !st.pwr;
    assign win_len  = ver_short ? WIN_S : WIN_L;
    assign dly_len  = ver_short ? DLY_S : DLY_L;

    ssq_deglitch #(.HOLD_CYC(BO_FILT_CYC)) u_bulk_filt (
        .clk(clk), .rst(rst), .clr(!supply_ok), .din(bulk_ok_raw), .dout(bulk_filt)
    );

    ssq_deglitch #(.HOLD_CYC(EN_FILT_CYC)) u_stop_filt (
        .clk(clk), .rst(rst), .clr(!supply_ok), .din(stop_req_raw), .dout(stop_filt)
    );

    // forced-sink window after power-up
    ssq_timer #(.W(CW)) u_win (
        .clk(clk), .rst(rst), .clr(!supply_ok), .load(sup_rise), .len(win_len), .busy(win_busy)
    );

    // settling delay: power-up or healthy-bulk return while idle
    assign bulk_next    = supply_ok && !sup_rise && !win_busy && bulk_filt;
    assign bulk_restart = bulk_next && !st.bulk_good && !dly_busy;

    ssq_timer #(.W(CW)) u_dly (
        .clk(clk), .rst(rst), .clr(!supply_ok), .load(sup_rise || bulk_restart),
        .len(dly_len), .busy(dly_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.pwr       <= supply_ok;
            st.bulk_good <= bulk_next;
            st.hot       <= over_temp;
            st.drv_prev  <= drv_en;
        end
    end

    assign stop_active = stop_filt && !ver_short;

    always_comb begin
        if (!st.pwr)
            phase = PH_OFF;
        else if (dly_busy)
            phase = PH_DELAY;
        else if (!st.bulk_good)
            phase = PH_WAIT;
        else if (st.hot || stop_active)
            phase = PH_HOLD;
        else
            phase = PH_RUN;
    end

    assign drv_en        = (phase == PH_RUN);
    assign ss_ground     = (phase == PH_OFF) || (phase == PH_DELAY);
    assign bias_sink_on  = !st.bulk_good;
    assign restart_pulse = drv_en && !st.drv_prev;

    assert_drv_needs_bulk_R5: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> !bias_sink_on)
        else $error("drivers on with sink active");

    assert_ground_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        ss_ground |-> !drv_en)
        else $error("drivers on while timing pin grounded");

    assert_window_sink_R3: assert property (@(posedge clk) disable iff (rst)
        win_busy |-> bias_sink_on)
        else $error("sink released inside forced window");

    assert_pulse_in_run_R9: assert property (@(posedge clk) disable iff (rst)
        restart_pulse |-> drv_en)
        else $error("restart strobe without drive");

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
        restart_pulse |=> !restart_pulse)
        else $error("restart strobe longer than one cycle");

    assert_hot_stops_R8: assert property (@(posedge clk) disable iff (rst)
        over_temp |=> !drv_en)
        else $error("drivers on after over-temperature");

    assert_supply_clear_R10: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (!drv_en && bias_sink_on && ss_ground))
        else $error("state not cleared on supply loss");

endmodule

// File: tb/hb_start_seq_bench.sv
module hb_start_seq_bench;

    localparam int DLY_L = 800;
    localparam int DLY_S = 100;
    localparam int WIN_L = 400;
    localparam int WIN_S = 50;
    localparam int BOF   = 8;
    localparam int ENF   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ver_short = 1'b0;
    logic supply_ok = 1'b0;
    logic bulk_ok_raw = 1'b1;
    logic stop_req_raw = 1'b0;
    logic over_temp = 1'b0;
    logic drv_en, bias_sink_on, ss_ground, restart_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hb_start_seq #(
        .DLY_LONG_CYC(DLY_L), .DLY_SHORT_CYC(DLY_S),
        .WIN_LONG_CYC(WIN_L), .WIN_SHORT_CYC(WIN_S),
        .BO_FILT_CYC(BOF), .EN_FILT_CYC(ENF)
    ) u_hb_start_seq (
        .clk(clk), .rst(rst), .ver_short(ver_short), .supply_ok(supply_ok),
        .bulk_ok_raw(bulk_ok_raw), .stop_req_raw(stop_req_raw), .over_temp(over_temp),
        .drv_en(drv_en), .bias_sink_on(bias_sink_on), .ss_ground(ss_ground),
        .restart_pulse(restart_pulse)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_up(input logic short_sel, input string rq, input string rw);
        int d;
        int w;
        d = short_sel ? DLY_S : DLY_L;
        w = short_sel ? WIN_S : WIN_L;
        ver_short = short_sel;
        supply_ok = 1'b1;
        step(1);
        chk(rw, "ss_ground after supply-up", ss_ground, 1'b1);
        chk(rw, "sink after supply-up", bias_sink_on, 1'b1);
        step(w);
        chk(rw, "sink at window end", bias_sink_on, 1'b1);
        step(1);
        chk(rw, "sink after window", bias_sink_on, 1'b0);
        step(d - w - 2);
        chk(rq, "drv one cycle before delay end", drv_en, 1'b0);
        chk("R2", "ss_ground during delay", ss_ground, 1'b1);
        step(1);
        chk(rq, "drv at delay end", drv_en, 1'b1);
        chk("R9", "restart strobe first cycle", restart_pulse, 1'b1);
        chk("R2", "ss_ground after delay", ss_ground, 1'b0);
        step(1);
        chk("R9", "restart strobe second cycle", restart_pulse, 1'b0);
        chk(rq, "drv stays on", drv_en, 1'b1);
    endtask

    task automatic t_reset;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R11", "drv after reset", drv_en, 1'b0);
        chk("R11", "strobe after reset", restart_pulse, 1'b0);
        chk("R11", "sink after reset", bias_sink_on, 1'b1);
        chk("R11", "ss_ground after reset", ss_ground, 1'b1);
    endtask

    task automatic t_bulk_glitch;
        bulk_ok_raw = 1'b0;
        step(BOF - 1);
        bulk_ok_raw = 1'b1;
        step(BOF + 2);
        chk("R4", "drv after short glitch", drv_en, 1'b1);
        chk("R4", "sink after short glitch", bias_sink_on, 1'b0);
    endtask

    task automatic t_bulk_drop_recover;
        bulk_ok_raw = 1'b0;
        step(BOF);
        chk("R4", "sink at filter edge", bias_sink_on, 1'b0);
        chk("R4", "drv at filter edge", drv_en, 1'b1);
        step(1);
        chk("R4", "sink after drop", bias_sink_on, 1'b1);
        chk("R4", "drv after drop", drv_en, 1'b0);
        step(5);
        bulk_ok_raw = 1'b1;
        step(BOF);
        chk("R5", "sink before recovery edge", bias_sink_on, 1'b1);
        step(1);
        chk("R5", "sink released on recovery", bias_sink_on, 1'b0);
        chk("R2", "ss_ground at recovery", ss_ground, 1'b1);
        step(DLY_L - 1);
        chk("R5", "drv one cycle before delay end", drv_en, 1'b0);
        step(1);
        chk("R5", "drv after recovery delay", drv_en, 1'b1);
        chk("R9", "strobe after recovery", restart_pulse, 1'b1);
        step(1);
    endtask

    task automatic t_stop_long;
        stop_req_raw = 1'b1;
        step(ENF - 1);
        chk("R6", "drv before stop filter", drv_en, 1'b1);
        step(1);
        chk("R6", "drv stopped", drv_en, 1'b0);
        chk("R6", "ss_ground while stopped", ss_ground, 1'b0);
        step(5);
        stop_req_raw = 1'b0;
        step(ENF - 1);
        chk("R6", "drv before release filter", drv_en, 1'b0);
        step(1);
        chk("R6", "drv resumes at once", drv_en, 1'b1);
        chk("R9", "strobe on stop release", restart_pulse, 1'b1);
        chk("R6", "no ground on release", ss_ground, 1'b0);
        step(1);
    endtask

    task automatic t_over_temp;
        over_temp = 1'b1;
        step(1);
        chk("R8", "drv under over-temp", drv_en, 1'b0);
        step(3);
        over_temp = 1'b0;
        step(1);
        chk("R8", "drv after over-temp clears", drv_en, 1'b1);
        chk("R8", "no ground after over-temp", ss_ground, 1'b0);
        chk("R9", "strobe after over-temp", restart_pulse, 1'b1);
        step(1);
    endtask

    task automatic t_supply_loss;
        supply_ok = 1'b0;
        step(1);
        chk("R10", "drv after supply loss", drv_en, 1'b0);
        chk("R10", "sink after supply loss", bias_sink_on, 1'b1);
        chk("R10", "ss_ground after supply loss", ss_ground, 1'b1);
        step(3);
    endtask

    task automatic t_stop_short;
        stop_req_raw = 1'b1;
        step(ENF + 4);
        chk("R7", "stop ignored in short version", drv_en, 1'b1);
        stop_req_raw = 1'b0;
        step(ENF + 1);
        chk("R7", "still running after stop pulse", drv_en, 1'b1);
    endtask

    task automatic t_bulk_low_start;
        bulk_ok_raw = 1'b0;
        ver_short = 1'b1;
        supply_ok = 1'b1;
        step(DLY_S + 5);
        chk("R3", "sink held with low bulk", bias_sink_on, 1'b1);
        chk("R1", "no drive with low bulk", drv_en, 1'b0);
        bulk_ok_raw = 1'b1;
        step(BOF + 1);
        chk("R5", "sink released late", bias_sink_on, 1'b0);
        chk("R2", "delay after late bulk", ss_ground, 1'b1);
        step(DLY_S);
        chk("R5", "drive after late bulk delay", drv_en, 1'b1);
    endtask

    initial begin
        t_reset();
        power_up(1'b0, "R1", "R3");
        t_bulk_glitch();
        t_bulk_drop_recover();
        t_stop_long();
        t_over_temp();
        t_supply_loss();
        power_up(1'b1, "R10", "R3");
        t_stop_short();
        t_supply_loss();
        t_bulk_low_start();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule